// File: doc/BRIEF.md
# Serial Sampling Converter Interface Controller

This block is the digital control logic on the device side of a 12-bit serial sampling converter. A host drives an active-low select line and a serial clock. The block answers on a serial data line that it can release to high impedance. Here that release is modelled as an output-enable bit next to the data bit. The select line going low samples the analog input and starts a conversion. In this block, that means the value on a parallel result port is captured and a one-clock sample strobe is sent to the successive-approximation stub that stands in for the analog core. The frame then shifts out four leading zeros followed by the 12 result bits, most significant first. Each bit is advanced by a falling serial clock edge.

The block tracks where in the frame the select line is released. Releasing it after the last bit ends the frame normally. Releasing it early aborts the frame. Releasing it after the 2nd falling edge and before the 10th puts the block into power-down. To leave power-down, the host runs a dummy frame that holds select low for more than 10 falling edges. Its data is flagged invalid. A counter on the free-running system clock then models the power-up delay, and any frame that starts before that delay has elapsed is also flagged invalid. A frame is also flagged invalid when the previous frame ended before the acquisition point, and for the first frame after reset.

Both pins are captured in the system clock domain, and their edges are found there. The system clock must run several times faster than the serial clock.

Top module: `adc_serial_ctl`

## Requirements
- R1: A falling edge of `cs_n` captures `conv_result`, pulses `sample_strobe` for exactly one clock and enables `sdo_oe`. Changes on `conv_result` after that edge do not alter the bits shifted out.
- R2: The first bit, driven when `cs_n` falls, is 0. Falling `sclk` edges 1 to 3 each drive a 0. Falling edges 4 to 15 drive result bits 11 down to 0 in turn.
- R3: The 16th falling `sclk` edge drops `sdo_oe`. Further `sclk` edges in the same frame leave it low.
- R4: While `cs_n` is high, `sdo_oe` is low, and `sclk` edges start nothing and strobe nothing.
- R5: `cs_n` rising before the 16th falling edge, with 0, 1 or 10 to 15 falling edges completed, aborts the frame. `sdo_oe` drops and `powered_down` stays 0.
- R6: A frame's `data_invalid` is 0 only if the previous frame kept `cs_n` low through the first `sclk` rise after its 13th falling edge. Otherwise it is 1.
- R7: `cs_n` rising with 2 to 9 falling edges completed in a frame sets `powered_down` to 1.
- R8: A frame started while powered down is a dummy frame. Its `data_invalid` is 1, and `powered_down` stays 1 during it. Releasing `cs_n` after at least 11 falling edges clears `powered_down`. Releasing it earlier leaves `powered_down` at 1.
- R9: A frame that starts fewer than `WAKE_CYCLES` system clocks after the dummy frame's `cs_n` fall has `data_invalid` = 1. A full frame that starts after that time, and follows a successful wake-up, has `data_invalid` = 0.
- R10: After reset, `sdo_oe`, `sample_strobe` and `powered_down` are 0, and the first frame has `data_invalid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| conv_result | input | RES_BITS | Result from the successive-approximation stub |
| sample_strobe | output | 1 | One-clock pulse marking the sampling instant |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Drive enable for `sdo`; low means high impedance |
| data_invalid | output | 1 | Marks the current frame's data as unusable |
| powered_down | output | 1 | Block is asleep or running a dummy wake-up frame |

## Verification
Each pin is registered once and then compared with its previous value, so a change on `cs_n` or `sclk` reaches `sdo`, `sdo_oe`, `sample_strobe`, `data_invalid` and `powered_down` at the second rising clock edge after the change. The bench changes a pin on a falling clock edge, waits four full clocks, and samples on the falling edge that follows. This places every sample two cycles clear of the update and well before the next pin change. For the power-up delay, the bench places frames either about 100 clocks after the dummy frame's start (before the 200-clock delay expires) or after an extra 300-clock idle gap (after it expires), so neither case sits near the boundary.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

    typedef enum logic [1:0] {
        PH_READY = 2'd0,   // idle, acquiring
        PH_CONV  = 2'd1,   // normal frame in progress
        PH_SLEEP = 2'd2,   // powered down
        PH_WAKE  = 2'd3    // dummy wake-up frame in progress
    } phase_t;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sclk_fall;
        logic sclk_rise;
    } pin_evt_t;

    // true when lo <= v < hi
    function automatic logic in_window(input int unsigned v,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (v >= lo) && (v < hi);
    endfunction

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
    parameter int               NPINS   = 2,
    parameter logic [NPINS-1:0] RST_LVL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pins_in,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic cur_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cur_q  <= RST_LVL[i];
                prev_q <= RST_LVL[i];
            end else begin
                cur_q  <= pins_in[i];
                prev_q <= cur_q;
            end
        end

        assign rise[i] = cur_q & ~prev_q;
        assign fall[i] = ~cur_q & prev_q;
    end

endmodule

// File: rtl/adc_wake_timer.sv
module adc_wake_timer #(
    parameter int WAKE_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cancel,
    output logic busy
);

    localparam int TW = $clog2(WAKE_CYCLES + 1);
    localparam logic [TW-1:0] LOAD = TW'(WAKE_CYCLES);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = (left_q != '0);

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_ctl_pkg::*;
#(
    parameter int RES_BITS   = 12,
    parameter int LEAD_ZEROS = 4,
    parameter int SLEEP_LO   = 2,
    parameter int SLEEP_HI   = 10,
    parameter int WAKE_FALLS = 11,
    parameter int ACQ_FALL   = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  pin_evt_t            evt,
    input  logic [RES_BITS-1:0] result,
    input  logic                timer_busy,
    output logic                sample_strobe,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                frame_bad,
    output logic                powered_down,
    output logic                wake_start,
    output logic                wake_cancel
);

    localparam int FRAME_BITS = LEAD_ZEROS + RES_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] ACQ_N     = CNT_W'(ACQ_FALL);
    localparam logic [CNT_W-1:0] WAKE_N    = CNT_W'(WAKE_FALLS);

    phase_t                phase_q;
    logic [CNT_W-1:0]      falls_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic                  acq_ok_q;

    logic sleep_hit, wake_ok, asleep;

    assign sleep_hit = in_window(32'(falls_q), SLEEP_LO, SLEEP_HI);
    assign wake_ok   = (falls_q >= WAKE_N);
    assign asleep    = (phase_q == PH_SLEEP);

    assign wake_start   = evt.cs_fall && asleep;
    assign wake_cancel  = evt.cs_rise && (phase_q == PH_WAKE) && !wake_ok;
    assign sdo          = shreg_q[FRAME_BITS-1];
    assign powered_down = asleep || (phase_q == PH_WAKE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q       <= PH_READY;
            falls_q       <= '0;
            shreg_q       <= '0;
            acq_ok_q      <= 1'b0;
            sdo_oe        <= 1'b0;
            sample_strobe <= 1'b0;
            frame_bad     <= 1'b0;
        end else begin
            sample_strobe <= 1'b0;
            unique case (phase_q)
                PH_READY, PH_SLEEP: begin
                    if (evt.cs_fall) begin
                        phase_q       <= asleep ? PH_WAKE : PH_CONV;
                        falls_q       <= '0;
                        shreg_q       <= {{LEAD_ZEROS{1'b0}}, result};
                        sdo_oe        <= 1'b1;
                        sample_strobe <= 1'b1;
                        frame_bad     <= asleep || timer_busy || !acq_ok_q;
                        acq_ok_q      <= 1'b0;
                    end
                end
                default: begin
                    if (evt.cs_rise) begin
                        sdo_oe  <= 1'b0;
                        falls_q <= '0;
                        if (sleep_hit) begin
                            phase_q <= PH_SLEEP;
                        end else if (phase_q == PH_WAKE) begin
                            phase_q <= wake_ok ? PH_READY : PH_SLEEP;
                            if (wake_ok) acq_ok_q <= 1'b1;
                        end else begin
                            phase_q <= PH_READY;
                        end
                    end else begin
                        if (evt.sclk_fall && falls_q < LAST_FALL) begin
                            falls_q <= falls_q + 1'b1;
                            shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
                            if (falls_q + 1'b1 == LAST_FALL) sdo_oe <= 1'b0;
                        end
                        if (evt.sclk_rise && phase_q == PH_CONV && falls_q >= ACQ_N)
                            acq_ok_q <= 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_serial_ctl.sv
module adc_serial_ctl
    import adc_ctl_pkg::*;
#(
    parameter int RES_BITS    = 12,
    parameter int LEAD_ZEROS  = 4,
    parameter int SLEEP_LO    = 2,
    parameter int SLEEP_HI    = 10,
    parameter int WAKE_FALLS  = 11,
    parameter int ACQ_FALL    = 13,
    parameter int WAKE_CYCLES = 200
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic [RES_BITS-1:0] conv_result,
    output logic                sample_strobe,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                data_invalid,
    output logic                powered_down
);

    logic [1:0] rise_v, fall_v;
    pin_evt_t   evt;
    logic       t_start, t_cancel, t_busy;

    // pin 0 = select, pin 1 = serial clock; both idle high
    adc_pin_sync #(
        .NPINS  (2),
        .RST_LVL(2'b11)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_in({sclk, cs_n}),
        .rise   (rise_v),
        .fall   (fall_v)
    );

    assign evt = '{cs_fall:   fall_v[0],
                   cs_rise:   rise_v[0],
                   sclk_fall: fall_v[1],
                   sclk_rise: rise_v[1]};

    adc_frame_seq #(
        .RES_BITS  (RES_BITS),
        .LEAD_ZEROS(LEAD_ZEROS),
        .SLEEP_LO  (SLEEP_LO),
        .SLEEP_HI  (SLEEP_HI),
        .WAKE_FALLS(WAKE_FALLS),
        .ACQ_FALL  (ACQ_FALL)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .result       (conv_result),
        .timer_busy   (t_busy),
        .sample_strobe(sample_strobe),
        .sdo          (sdo),
        .sdo_oe       (sdo_oe),
        .frame_bad    (data_invalid),
        .powered_down (powered_down),
        .wake_start   (t_start),
        .wake_cancel  (t_cancel)
    );

    adc_wake_timer #(
        .WAKE_CYCLES(WAKE_CYCLES)
    ) u_wake (
        .clk   (clk),
        .rst   (rst),
        .start (t_start),
        .cancel(t_cancel),
        .busy  (t_busy)
    );

endmodule

// File: rtl/adc_serial_ctl_chk.sv
module adc_serial_ctl_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sample_strobe,
    input logic sdo,
    input logic sdo_oe,
    input logic data_invalid,
    input logic powered_down
);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> !sample_strobe); // R1

    AST_STROBE_OPENS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |-> (sdo_oe && !$past(sdo_oe))); // R1

    AST_FIRST_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> !sdo); // R2

    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdo_oe); // R4

    AST_SLEEP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        $rose(powered_down) |-> !sdo_oe); // R7

    AST_DUMMY_INVALID: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && powered_down) |-> data_invalid); // R8

endmodule

bind adc_serial_ctl adc_serial_ctl_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_n         (cs_n),
    .sample_strobe(sample_strobe),
    .sdo          (sdo),
    .sdo_oe       (sdo_oe),
    .data_invalid (data_invalid),
    .powered_down (powered_down)
);

// File: tb/test_adc_serial_ctl.sv
module test_adc_serial_ctl;

    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] conv_result = '0;
    logic        sample_strobe, sdo, sdo_oe, data_invalid, powered_down;

    int errs = 0;
    int checks = 0;
    int strobes = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_serial_ctl i_adc_serial_ctl (
        .clk          (clk),
        .rst          (rst),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .conv_result  (conv_result),
        .sample_strobe(sample_strobe),
        .sdo          (sdo),
        .sdo_oe       (sdo_oe),
        .data_invalid (data_invalid),
        .powered_down (powered_down)
    );

    always @(posedge clk) if (!rst && sample_strobe) strobes++;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_bit(input logic [11:0] v, input int k);
        if (k < 4) return 0;
        return int'(v[15-k]);
    endfunction

    // one frame: select low, 'falls' serial clock pulses, select high
    task automatic frame(input logic [11:0] val, input int falls,
                         input int exp_inv, input string inv_tag);
        int s0;
        s0 = strobes;
        conv_result = val;
        cs_n = 1'b0;
        wt(HOLD);
        chk("R1 one strobe per frame start", strobes, s0 + 1);
        chk("R1 output enabled at start", int'(sdo_oe), 1);
        chk("R2 first bit zero", int'(sdo), 0);
        chk(inv_tag, int'(data_invalid), exp_inv);
        conv_result = ~val;   // R1: later stub changes must not leak
        for (int k = 1; k <= falls; k++) begin
            sclk = 1'b0;
            wt(HOLD);
            if (k < 16) chk($sformatf("R2 bit after fall %0d", k), int'(sdo), exp_bit(val, k));
            else        chk("R3 released after last fall", int'(sdo_oe), 0);
            sclk = 1'b1;
            wt(HOLD);
        end
        cs_n = 1'b1;
        wt(HOLD);
        chk("R4 released when deselected", int'(sdo_oe), 0);
    endtask

    task automatic t_reset();
        chk("R10 oe after reset", int'(sdo_oe), 0);
        chk("R10 strobe after reset", int'(sample_strobe), 0);
        chk("R10 powered_down after reset", int'(powered_down), 0);
    endtask

    task automatic t_first_and_normal();
        frame(12'hA5C, 16, 1, "R10 first frame invalid");
        frame(12'h5A3, 16, 0, "R6 full frame keeps next valid");
        frame(12'h001, 18, 0, "R6 valid after full frame");   // R3 extra edges
        chk("R5 no sleep after full frames", int'(powered_down), 0);
    endtask

    task automatic t_deselected_clock();
        int s0;
        s0 = strobes;
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b0; wt(HOLD);
            chk("R4 sclk ignored while deselected", int'(sdo_oe), 0);
            sclk = 1'b1; wt(HOLD);
        end
        chk("R4 no strobe while deselected", strobes, s0);
        chk("R4 no power-down while deselected", int'(powered_down), 0);
    endtask

    task automatic t_abort(input int falls, input int next_inv);
        frame(12'h3C7, falls, 0, "R6 valid before abort");
        chk($sformatf("R5 abort at %0d falls stays powered", falls), int'(powered_down), 0);
        frame(12'hFFF, 16, next_inv, "R6 validity after early release");
        frame(12'h800, 16, 0, "R6 valid after recovery");
    endtask

    task automatic t_sleep(input int falls);
        frame(12'h6B2, falls, 0, "R6 valid before sleep");
        chk($sformatf("R7 sleep after %0d falls", falls), int'(powered_down), 1);
    endtask

    task automatic t_wake_fail();
        frame(12'h111, 10, 1, "R8 dummy frame invalid");
        chk("R8 short dummy keeps sleeping", int'(powered_down), 1);
    endtask

    task automatic t_wake_then_early_frame();
        frame(12'h222, 11, 1, "R8 dummy frame invalid");
        chk("R8 wake after 11 falls", int'(powered_down), 0);
        frame(12'h9E4, 16, 1, "R9 frame inside wake delay invalid");
        wt(300);
        frame(12'h4D1, 16, 0, "R9 frame after delay valid");
    endtask

    task automatic t_wake_then_late_frame();
        frame(12'h333, 11, 1, "R8 dummy frame invalid");
        chk("R8 wake after 11 falls", int'(powered_down), 0);
        wt(300);
        frame(12'hC3A, 16, 0, "R9 first frame after delay valid");
    endtask

    initial begin
        wt(6);
        rst = 1'b0;
        wt(2);
        t_reset();
        t_first_and_normal();
        t_deselected_clock();
        t_abort(12, 1);        // R5, R6: released before acquisition point
        t_abort(14, 0);        // R6: released after acquisition point
        t_abort(1, 1);         // R5: boundary below sleep window
        t_abort(10, 1);        // R5: boundary above sleep window
        t_sleep(5);            // R7
        t_wake_fail();         // R8
        t_wake_then_early_frame();
        t_sleep(9);            // R7 upper edge
        t_wake_then_late_frame();
        t_sleep(2);            // R7 lower edge
        t_wake_then_late_frame();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule